// File: doc/BRIEF.md
# Float to Integer Converter

This block turns a floating-point operand of configurable exponent and fraction width into an integer of configurable width. It is purely combinational: the integer and its invalid flag follow the operand and the signedness select with no register in between, so the surrounding pipeline decides where to put its own stage.

The operand's biased exponent is removed, the significand with its implied leading one is shifted so that the binary point lands at the integer boundary, and every bit below that point is dropped (truncation toward zero). When the signed mode is chosen and the operand is negative, the magnitude is negated in two's complement. Any operand the integer cannot represent exactly enough, and every zero, yields an integer of zero together with the invalid flag; no output ever saturates.

Top module: `fp_to_int_conv`

## Requirements
- R1: The outputs depend only on the present values of `fp_i` and `signed_mode_i`; they settle without any clock edge.
- R2: A normal, positive operand whose unbiased exponent e satisfies 0 <= e < limit gives the integer floor(value) with `invalid_o` = 0, where limit is `INT_W` in unsigned mode (`signed_mode_i` = 0) and `INT_W`-1 in signed mode (`signed_mode_i` = 1).
- R3: A normal, negative operand in range with signed mode selected gives the two's-complement negation of the truncated magnitude, `invalid_o` = 0.
- R4: A negative operand (sign bit, the MSB of `fp_i`, equal to 1) with unsigned mode selected gives 0 and `invalid_o` = 1.
- R5: Positive and negative zero (exponent field and fraction field both 0) give 0 and `invalid_o` = 1.
- R6: Any operand with an unbiased exponent below zero, including all subnormals (exponent field 0, fraction nonzero), gives 0 and `invalid_o` = 1.
- R7: A normal operand with unbiased exponent at or above the limit of R2 gives 0 and `invalid_o` = 1.
- R8: An operand whose exponent field is all ones (infinity or NaN) gives 0 and `invalid_o` = 1.
- R9: Whenever `invalid_o` is 1, `int_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fp_i | input | 1+EXP_W+MAN_W | Operand: sign in the MSB, then biased exponent, then fraction in the low bits |
| signed_mode_i | input | 1 | 1 selects a two's-complement result, 0 an unsigned result |
| int_o | output | INT_W | Converted integer, zero when invalid |
| invalid_o | output | 1 | Set when the operand has no valid integer form |

## Verification
The bound checker watches, whenever inputs change, that an invalid result is always zero, that zeros, infinities, NaNs and negative operands in unsigned mode always raise the flag, and that a valid signed result carries the operand's sign. The exact truncated value, the exponent limits that differ between the two modes and the negation of the magnitude are only shown by the bench, which sweeps every operand of a small format in both modes and computes the expected integer arithmetically, plus a few spot values in the default single-precision format.

// File: rtl/fp_to_int_pkg.sv
package fp_to_int_pkg;

  typedef enum logic [2:0] {
    FPC_ZERO = 3'd0,
    FPC_SUB  = 3'd1,
    FPC_NORM = 3'd2,
    FPC_INF  = 3'd3,
    FPC_NAN  = 3'd4
  } fp_class_t;

endpackage

// File: rtl/fp_to_int_unpack.sv
module fp_to_int_unpack
  import fp_to_int_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] fp_i,
  output logic                 sign_o,
  output fp_class_t            cls_o,
  output int                   unb_exp_o,
  output logic [MAN_W-1:0]     frac_o
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  logic [EXP_W-1:0] exp_f;

  assign sign_o = fp_i[EXP_W+MAN_W];
  assign exp_f  = fp_i[MAN_W +: EXP_W];
  assign frac_o = fp_i[MAN_W-1:0];

  always_comb begin
    unb_exp_o = int'({1'b0, exp_f}) - BIAS;
    if (exp_f == '0)
      cls_o = (frac_o == '0) ? FPC_ZERO : FPC_SUB;
    else if (exp_f == '1)
      cls_o = (frac_o == '0) ? FPC_INF : FPC_NAN;
    else
      cls_o = FPC_NORM;
  end
endmodule

// File: rtl/fp_to_int_range.sv
module fp_to_int_range
  import fp_to_int_pkg::*;
#(
  parameter int INT_W = 32,
  localparam int SHW  = (INT_W > 2) ? $clog2(INT_W) : 1
) (
  input  fp_class_t        cls_i,
  input  logic             sign_i,
  input  int               unb_exp_i,
  input  logic             signed_mode_i,
  output logic             ok_o,
  output logic [SHW-1:0]   shamt_o
);
  int limit;

  always_comb begin
    limit   = signed_mode_i ? (INT_W - 1) : INT_W;
    ok_o    = (cls_i == FPC_NORM) && (unb_exp_i >= 0) && (unb_exp_i < limit)
              && !(sign_i && !signed_mode_i);
    shamt_o = ok_o ? unb_exp_i[SHW-1:0] : '0;
  end
endmodule

// File: rtl/fp_to_int_align.sv
module fp_to_int_align #(
  parameter int MAN_W = 23,
  parameter int INT_W = 32,
  localparam int SHW  = (INT_W > 2) ? $clog2(INT_W) : 1,
  localparam int AW   = MAN_W + 1 + INT_W
) (
  input  logic [MAN_W-1:0] frac_i,
  input  logic [SHW-1:0]   shamt_i,
  output logic [INT_W-1:0] mag_o
);
  logic [AW-1:0] sig_ext;

  always_comb begin
    sig_ext = AW'({1'b1, frac_i});
    mag_o   = INT_W'((sig_ext << shamt_i) >> MAN_W);
  end
endmodule

// File: rtl/fp_to_int_sign.sv
module fp_to_int_sign #(
  parameter int INT_W = 32
) (
  input  logic [INT_W-1:0] mag_i,
  input  logic             neg_i,
  input  logic             ok_i,
  output logic [INT_W-1:0] int_o,
  output logic             invalid_o
);
  always_comb begin
    invalid_o = !ok_i;
    if (!ok_i)      int_o = '0;
    else if (neg_i) int_o = (~mag_i) + INT_W'(1);
    else            int_o = mag_i;
  end
endmodule

// File: rtl/fp_to_int_conv.sv
module fp_to_int_conv
  import fp_to_int_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32,
  localparam int SHW  = (INT_W > 2) ? $clog2(INT_W) : 1
) (
  input  logic [EXP_W+MAN_W:0] fp_i,
  input  logic                 signed_mode_i,
  output logic [INT_W-1:0]     int_o,
  output logic                 invalid_o
);
  logic             sign;
  fp_class_t        cls;
  int               unb_exp;
  logic [MAN_W-1:0] frac;
  logic             ok;
  logic [SHW-1:0]   shamt;
  logic [INT_W-1:0] mag;

  fp_to_int_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
    .fp_i(fp_i), .sign_o(sign), .cls_o(cls), .unb_exp_o(unb_exp), .frac_o(frac)
  );

  fp_to_int_range #(.INT_W(INT_W)) u_range (
    .cls_i(cls), .sign_i(sign), .unb_exp_i(unb_exp),
    .signed_mode_i(signed_mode_i), .ok_o(ok), .shamt_o(shamt)
  );

  fp_to_int_align #(.MAN_W(MAN_W), .INT_W(INT_W)) u_align (
    .frac_i(frac), .shamt_i(shamt), .mag_o(mag)
  );

  fp_to_int_sign #(.INT_W(INT_W)) u_sign (
    .mag_i(mag), .neg_i(sign), .ok_i(ok), .int_o(int_o), .invalid_o(invalid_o)
  );
endmodule

// File: rtl/fp_to_int_conv_chk.sv
module fp_to_int_conv_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32
) (
  input logic [EXP_W+MAN_W:0] fp_i,
  input logic                 signed_mode_i,
  input logic [INT_W-1:0]     int_o,
  input logic                 invalid_o
);
  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] fr;

  assign sgn = fp_i[EXP_W+MAN_W];
  assign ex  = fp_i[MAN_W +: EXP_W];
  assign fr  = fp_i[MAN_W-1:0];

  always_comb begin
    // R9
    zero_when_invalid_chk: assert (!invalid_o || int_o == '0)
      else $error("invalid result not zero");
    // R5
    zero_in_invalid_chk: assert (!(ex == '0 && fr == '0) || invalid_o)
      else $error("zero operand not flagged");
    // R8
    special_in_invalid_chk: assert (!(ex == '1) || invalid_o)
      else $error("inf or NaN not flagged");
    // R4
    neg_unsigned_chk: assert (!(sgn && !signed_mode_i) || invalid_o)
      else $error("negative operand accepted in unsigned mode");
    // R3
    neg_result_sign_chk: assert (!(signed_mode_i && !invalid_o && sgn) || int_o[INT_W-1])
      else $error("negative operand gave non-negative integer");
    // R2
    pos_result_sign_chk: assert (!(signed_mode_i && !invalid_o && !sgn) || !int_o[INT_W-1])
      else $error("positive operand gave negative integer");
  end
endmodule

bind fp_to_int_conv fp_to_int_conv_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_chk (
  .fp_i(fp_i), .signed_mode_i(signed_mode_i), .int_o(int_o), .invalid_o(invalid_o)
);

// File: tb/tb_fp_to_int_conv.sv
`timescale 1ns/1ps
module tb_fp_to_int_conv;
  localparam int SE = 4, SM = 3, SI = 6;
  localparam int SBIAS = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [SE+SM:0] s_fp;
  logic           s_sm;
  logic [SI-1:0]  s_int;
  logic           s_inv;

  logic [31:0]    b_fp;
  logic           b_sm;
  logic [31:0]    b_int;
  logic           b_inv;

  fp_to_int_conv #(.EXP_W(SE), .MAN_W(SM), .INT_W(SI)) dut (
    .fp_i(s_fp), .signed_mode_i(s_sm), .int_o(s_int), .invalid_o(s_inv)
  );

  fp_to_int_conv dut_sp (
    .fp_i(b_fp), .signed_mode_i(b_sm), .int_o(b_int), .invalid_o(b_inv)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic check(input string req, input longint act, input longint exp_v,
                       input bit act_i, input bit exp_i);
    checks++;
    if (act != exp_v || act_i != exp_i) begin
      fails++;
      $display("FAIL %s: got int=%0d inv=%0b, expected int=%0d inv=%0b",
               req, act, act_i, exp_v, exp_i);
    end
  endtask

  task automatic big(input logic [31:0] f, input bit sm, input longint ev, input bit ei,
                     input string req);
    b_fp = f; b_sm = sm;
    #2;
    check(req, longint'(b_int), ev, b_inv, ei);
  endtask

  initial begin
    #200000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    s_fp = '0; s_sm = 1'b0; b_fp = '0; b_sm = 1'b0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R5: initial all-zero operand
    check("R5", longint'(s_int), 0, s_inv, 1'b1);

    // R1: a change between clock edges shows up without any edge
    @(posedge clk); #3;
    s_fp = 8'h48; // exp 9 -> unbiased 2, 1.000 -> 4
    #1;
    check("R1", longint'(s_int), 4, s_inv, 1'b0);

    for (int sm = 0; sm < 2; sm++) begin
      for (int f = 0; f < 256; f++) begin
        int e, m, s, ue, lim, mag, ev;
        bit ei;
        string req;
        @(negedge clk);
        s_fp = f[7:0]; s_sm = sm[0];
        #5;
        s = f >> 7; e = (f >> SM) & 15; m = f & 7;
        ue = e - SBIAS; lim = sm ? SI - 1 : SI;
        ei = 1'b0; ev = 0;
        if (e == 15)               begin ei = 1; req = "R8"; end
        else if (e == 0 && m == 0) begin ei = 1; req = "R5"; end
        else if (ue < 0)           begin ei = 1; req = "R6"; end
        else if (s == 1 && sm == 0) begin ei = 1; req = "R4"; end
        else if (ue >= lim)        begin ei = 1; req = "R7"; end
        else begin
          mag = ((8 + m) << ue) >> SM;
          if (s == 1) begin ev = (-mag) & 63; req = "R3"; end
          else        begin ev = mag;         req = "R2"; end
        end
        check(req, longint'(s_int), longint'(ev), s_inv, ei);
        // R9: invalid always comes with zero
        if (s_inv) check("R9", longint'(s_int), 0, 1'b1, 1'b1);
      end
    end

    // default single-precision spot values
    big(32'h40700000, 1'b0, 3, 1'b0, "R2");                 // 3.75
    big(32'hC2C90000, 1'b1, 64'h00000000FFFFFF9C, 1'b0, "R3"); // -100.5 -> -100
    big(32'h4F000000, 1'b1, 0, 1'b1, "R7");                 // 2^31 signed
    big(32'h4F000000, 1'b0, 64'h0000000080000000, 1'b0, "R2"); // 2^31 unsigned
    big(32'h4F800000, 1'b0, 0, 1'b1, "R7");                 // 2^32 unsigned
    big(32'h80000000, 1'b1, 0, 1'b1, "R5");                 // -0
    big(32'h3F7FFFFF, 1'b0, 0, 1'b1, "R6");                 // just below 1
    big(32'h7FC00000, 1'b1, 0, 1'b1, "R8");                 // NaN
    big(32'hBF800000, 1'b0, 0, 1'b1, "R4");                 // -1 unsigned

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule